// File: doc/BRIEF.md
# Distinct-Bias Oscillator Configuration Selector

This block holds a table of entropy scores, one for each of three noise oscillators at each of four bias settings. On a start strobe it searches every assignment in which the three oscillators use three different biases. Oscillators that share a bias can lock onto nearly the same frequency, so such assignments are never considered. It evaluates one candidate per clock and keeps the assignment with the largest summed score. When the search ends it compares that sum with a pass threshold.

The result is a packed bias word and four control words. Words 0 to 2 each program one oscillator with its chosen bias. Word 3 enables all three oscillators together. A per-cell readout of the winning biases and scores is also produced, and it is forced to zero when the entropy is insufficient. Software or a sequencer loads the table through a simple write port and then pulses start. Measuring the entropy is done elsewhere.

Top module: `osc_bias_selector`

## Requirements
- R1: After reset, busy, done and low_entropy are 0, best_sum is 0, bias_word is 0x24, cell_bias and cell_score are 0, and every control word has count 0.
- R2: When wr_en is high and busy is low, wr_score is stored for oscillator wr_osc at bias wr_bias. A write with wr_osc equal to 3 is ignored. A write while busy is high is ignored.
- R3: A start pulse sampled while idle begins a search of exactly the 24 triples (b0,b1,b2) whose three biases all differ. busy is high during the search. done is high for exactly one cycle, 24 cycles after the edge that sampled start.
- R4: Candidates are visited with b0 in the outermost loop, then b1, then b2, each ascending. A candidate replaces the current best only when its sum is strictly greater, so among equal maxima the first one visited wins.
- R5: Each search starts from best sum 0 and the default assignment 0x24 (oscillator n at bias n). If no candidate sum exceeds 0, the default assignment is kept.
- R6: bias_word packs the bias of oscillator n in bits [2n+1:2n]. best_sum is the sum of the three scores of the chosen assignment.
- R7: At done, low_entropy is 1 exactly when best_sum < 150000000. In that case cell_bias and cell_score are cleared to 0.
- R8: At done, when low_entropy is 0, cell_bias equals bias_word, and cell_score[n] equals the chosen score of oscillator n.
- R9: Control word n (n = 0..2) has select = 1<<n in bits [21:19], the bias of oscillator n in bits [18:17], the mode bit (1 = normal) in bit 16, and acc_cycles as sampled at start in bits [15:0].
- R10: Control word 3 has select 3'b111, bias field 0, mode bit 1, and the same count.
- R11: A start pulse while busy is ignored. It neither restarts the search nor changes the latched count.
- R12: Sums are formed at 66 bits without overflow. With all scores at 2^64-1, best_sum is 3*(2^64-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Score table write enable |
| wr_osc | input | 2 | Oscillator index of the write |
| wr_bias | input | 2 | Bias index of the write |
| wr_score | input | 64 | Score value written |
| start | input | 1 | Begin a search |
| acc_cycles | input | 16 | Accumulate-cycle count placed in control words |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse at the end of a search |
| bias_word | output | 6 | Packed chosen biases, 2 bits per oscillator |
| best_sum | output | 66 | Best summed score |
| low_entropy | output | 1 | Best sum below the pass threshold |
| cell_bias | output | 6 | Per-cell bias readout (zero when low) |
| cell_score | output | 3x64 | Per-cell chosen score readout (zero when low) |
| ctl_words | output | 4x22 | Control words 0..2 per oscillator, 3 for all |

## Verification
The assertions take the start strobe to be synchronous and the table contents to be stable while a search runs. The design enforces the second point itself, because it blocks writes while busy. The best sum is taken to never fall during a search. The chosen bias fields are taken to always differ from one another, starting from the reset default. The stimulus changes inputs only on the falling edge. It issues writes and extra start pulses during a search only to show that they are refused, and it compares every completed search against a nested-loop model of the 24 permutations.

// File: rtl/sel_pkg.sv
package sel_pkg;
  localparam int NOSC    = 3;
  localparam int NBIAS   = 4;
  localparam int BIAS_W  = $clog2(NBIAS);
  localparam int BWORD_W = NOSC * BIAS_W;
  localparam int NPERM   = 24;
  localparam int IDX_W   = $clog2(NPERM);
  localparam logic [BWORD_W-1:0] DEFAULT_BIAS = 6'b10_01_00;

  // idx-th triple with distinct biases; b0 outermost, returned as {b2,b1,b0}
  function automatic logic [BWORD_W-1:0] perm_at(input logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] k;
    logic [BWORD_W-1:0] res;
    logic [5:0] cv;
    k   = '0;
    res = DEFAULT_BIAS;
    for (int c = 0; c < 64; c++) begin
      cv = c[5:0];
      if (cv[5:4] != cv[3:2] && cv[5:4] != cv[1:0] && cv[3:2] != cv[1:0]) begin
        if (k == idx) res = {cv[1:0], cv[3:2], cv[5:4]};
        k = k + 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic [65:0] sum3(input logic [63:0] a,
                                       input logic [63:0] b,
                                       input logic [63:0] c);
    return {2'b00, a} + {2'b00, b} + {2'b00, c};
  endfunction
endpackage

// File: rtl/sel_score_table.sv
module sel_score_table
  import sel_pkg::*;
#(
  parameter int SCORE_W = 64
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       we,
  input  logic [1:0]                                 osc,
  input  logic [BIAS_W-1:0]                          bias,
  input  logic [SCORE_W-1:0]                         data,
  output logic [NOSC-1:0][NBIAS-1:0][SCORE_W-1:0]    table_q
);
  for (genvar o = 0; o < NOSC; o++) begin : g_osc
    for (genvar b = 0; b < NBIAS; b++) begin : g_bias
      always_ff @(posedge clk) begin
        if (!rst_n) table_q[o][b] <= '0;
        else if (we && osc == 2'(o) && bias == BIAS_W'(b)) table_q[o][b] <= data;
      end
    end
  end
endmodule

// File: rtl/sel_perm_seq.sv
module sel_perm_seq
  import sel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  output logic               busy,
  output logic               last,
  output logic [BWORD_W-1:0] cand_bias
);
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  assign last      = busy && (idx == IDX_W'(NPERM - 1));
  assign cand_bias = perm_at(idx);

  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx < IDX_W'(NPERM));
  p_cand_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cand_bias[1:0] != cand_bias[3:2] && cand_bias[1:0] != cand_bias[5:4]
              && cand_bias[3:2] != cand_bias[5:4]));
endmodule

// File: rtl/sel_ctl_build.sv
module sel_ctl_build
  import sel_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int CTL_W = CNT_W + 1 + BIAS_W + NOSC
) (
  input  logic [BWORD_W-1:0]           bias_word,
  input  logic [CNT_W-1:0]             count,
  output logic [NOSC:0][CTL_W-1:0]     ctl
);
  localparam logic MODE_NORMAL = 1'b1;

  for (genvar n = 0; n < NOSC; n++) begin : g_cell
    assign ctl[n] = {NOSC'(1 << n), bias_word[BIAS_W*n +: BIAS_W], MODE_NORMAL, count};
  end
  assign ctl[NOSC] = {{NOSC{1'b1}}, {BIAS_W{1'b0}}, MODE_NORMAL, count};
endmodule

// File: rtl/osc_bias_selector.sv
module osc_bias_selector
  import sel_pkg::*;
#(
  parameter int          SCORE_W  = 64,
  parameter int          CNT_W    = 16,
  parameter logic [65:0] PASS_MIN = 66'd150000000,
  localparam int         SUM_W    = SCORE_W + 2,
  localparam int         CTL_W    = CNT_W + 1 + BIAS_W + NOSC
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [1:0]                        wr_osc,
  input  logic [BIAS_W-1:0]                 wr_bias,
  input  logic [SCORE_W-1:0]                wr_score,
  input  logic                              start,
  input  logic [CNT_W-1:0]                  acc_cycles,
  output logic                              busy,
  output logic                              done,
  output logic [BWORD_W-1:0]                bias_word,
  output logic [SUM_W-1:0]                  best_sum,
  output logic                              low_entropy,
  output logic [BWORD_W-1:0]                cell_bias,
  output logic [NOSC-1:0][SCORE_W-1:0]      cell_score,
  output logic [NOSC:0][CTL_W-1:0]          ctl_words
);
  logic [NOSC-1:0][NBIAS-1:0][SCORE_W-1:0] table_q;
  logic                                    go, last, better, fin_low;
  logic [BWORD_W-1:0]                      cand_bias, fin_bias;
  logic [NOSC-1:0][SCORE_W-1:0]            cand_cells, run_cells, fin_cells;
  logic [SUM_W-1:0]                        cand_sum, fin_sum;
  logic [CNT_W-1:0]                        cnt_q;
  logic                                    tbl_we;

  assign go     = start && !busy;
  assign tbl_we = wr_en && !busy && (wr_osc != 2'd3);

  sel_score_table #(.SCORE_W(SCORE_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .osc(wr_osc), .bias(wr_bias),
    .data(wr_score), .table_q(table_q));

  sel_perm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .last(last),
    .cand_bias(cand_bias));

  for (genvar n = 0; n < NOSC; n++) begin : g_pick
    assign cand_cells[n] = table_q[n][cand_bias[BIAS_W*n +: BIAS_W]];
  end

  assign cand_sum  = sum3(cand_cells[0], cand_cells[1], cand_cells[2]);
  assign better    = cand_sum > best_sum;
  assign fin_sum   = better ? cand_sum  : best_sum;
  assign fin_bias  = better ? cand_bias : bias_word;
  assign fin_cells = better ? cand_cells : run_cells;
  assign fin_low   = fin_sum < PASS_MIN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done        <= 1'b0;
      best_sum    <= '0;
      bias_word   <= DEFAULT_BIAS;
      run_cells   <= '0;
      cnt_q       <= '0;
      low_entropy <= 1'b0;
      cell_bias   <= '0;
      cell_score  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        best_sum  <= '0;
        bias_word <= DEFAULT_BIAS;
        run_cells <= '0;
        cnt_q     <= acc_cycles;
      end else if (busy) begin
        best_sum  <= fin_sum;
        bias_word <= fin_bias;
        run_cells <= fin_cells;
        if (last) begin
          done        <= 1'b1;
          low_entropy <= fin_low;
          cell_bias   <= fin_low ? '0 : fin_bias;
          cell_score  <= fin_low ? '0 : fin_cells;
        end
      end
    end
  end

  sel_ctl_build #(.CNT_W(CNT_W)) u_ctl (
    .bias_word(bias_word), .count(cnt_q), .ctl(ctl_words));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  p_best_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> best_sum >= $past(best_sum));
  p_bias_distinct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bias_word[1:0] != bias_word[3:2] && bias_word[1:0] != bias_word[5:4]
    && bias_word[3:2] != bias_word[5:4]);
  p_low_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> low_entropy == (best_sum < PASS_MIN));
  p_cells_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && low_entropy) |-> (cell_bias == '0 && cell_score == '0));
  p_cells_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !low_entropy) |-> cell_bias == bias_word);
  p_count_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cnt_q));
endmodule

// File: tb/tb_osc_bias_selector.sv
module tb_osc_bias_selector;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_osc = 0;
  logic [1:0] wr_bias = 0;
  logic [63:0] wr_score = 0;
  logic start = 0;
  logic [15:0] acc_cycles = 0;
  logic busy, done, low_entropy;
  logic [5:0] bias_word, cell_bias;
  logic [65:0] best_sum;
  logic [2:0][63:0] cell_score;
  logic [3:0][21:0] ctl_words;

  int checks = 0;
  int errors = 0;
  logic [63:0] mt [3][4];
  logic [65:0] e_best;
  logic [5:0]  e_bias;
  logic [63:0] e_cell [3];
  logic [63:0] lcg = 64'h1234_5678_9abc_def1;

  always #5 clk = ~clk;

  osc_bias_selector dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_osc(wr_osc), .wr_bias(wr_bias),
    .wr_score(wr_score), .start(start), .acc_cycles(acc_cycles), .busy(busy),
    .done(done), .bias_word(bias_word), .best_sum(best_sum),
    .low_entropy(low_entropy), .cell_bias(cell_bias), .cell_score(cell_score),
    .ctl_words(ctl_words));

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] o, input logic [1:0] b, input logic [63:0] v);
    @(negedge clk);
    wr_en = 1; wr_osc = o; wr_bias = b; wr_score = v;
    @(negedge clk);
    wr_en = 0;
    if (o != 2'd3) mt[o][b] = v;
  endtask

  task automatic load_all(input logic [63:0] v [3][4]);
    for (int o = 0; o < 3; o++)
      for (int b = 0; b < 4; b++) wr(2'(o), 2'(b), v[o][b]);
  endtask

  // nested-loop reference over distinct triples, strict greater
  task automatic model();
    logic [65:0] s;
    e_best = 0; e_bias = 6'h24;
    for (int k = 0; k < 3; k++) e_cell[k] = 0;
    for (int b0 = 0; b0 < 4; b0++)
      for (int b1 = 0; b1 < 4; b1++)
        for (int b2 = 0; b2 < 4; b2++) begin
          if (b0 == b1 || b0 == b2 || b1 == b2) continue;
          s = 66'(mt[0][b0]) + 66'(mt[1][b1]) + 66'(mt[2][b2]);
          if (s > e_best) begin
            e_best = s;
            e_bias = {2'(b2), 2'(b1), 2'(b0)};
            e_cell[0] = mt[0][b0]; e_cell[1] = mt[1][b1]; e_cell[2] = mt[2][b2];
          end
        end
  endtask

  // start, optionally re-pulse start mid-run with another count; returns cycles to done
  task automatic run(input logic [15:0] cnt, input bit repulse, input bit wr_mid, output int n);
    @(negedge clk);
    start = 1; acc_cycles = cnt;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      start = 0;
      wr_en = 0;
      if (repulse && n == 5) begin start = 1; acc_cycles = cnt ^ 16'hFFFF; end
      if (wr_mid && n == 7) begin wr_en = 1; wr_osc = 0; wr_bias = 2; wr_score = '1; end
    end while (!done && n < 100);
    start = 0; wr_en = 0;
  endtask

  task automatic check_result(input string tag, input logic [15:0] cnt);
    logic low;
    model();
    low = e_best < 66'd150000000;
    chk({tag, " R6 best_sum"}, 256'(best_sum), 256'(e_best));
    chk({tag, " R4 bias_word"}, 256'(bias_word), 256'(e_bias));
    chk({tag, " R7 low_entropy"}, 256'(low_entropy), 256'(low));
    chk({tag, " R8 cell_bias"}, 256'(cell_bias), low ? 256'(0) : 256'(e_bias));
    for (int k = 0; k < 3; k++)
      chk({tag, " R8 cell_score"}, 256'(cell_score[k]), low ? 256'(0) : 256'(e_cell[k]));
    for (int k = 0; k < 3; k++)
      chk({tag, " R9 ctl word"}, 256'(ctl_words[k]),
          256'({3'(1 << k), e_bias[2*k +: 2], 1'b1, cnt}));
    chk({tag, " R10 ctl all"}, 256'(ctl_words[3]), 256'({3'b111, 2'b00, 1'b1, cnt}));
  endtask

  task automatic full_run(input string tag, input logic [15:0] cnt);
    int n;
    run(cnt, 0, 0, n);
    chk({tag, " R3 cycles to done"}, 256'(n), 256'(25));
    check_result(tag, cnt);
    @(negedge clk);
    chk({tag, " R3 done one cycle"}, 256'(done), 256'(0));
  endtask

  task automatic t_reset();
    chk("R1 busy", 256'(busy), 0);
    chk("R1 done", 256'(done), 0);
    chk("R1 best", 256'(best_sum), 0);
    chk("R1 bias", 256'(bias_word), 256'(6'h24));
    chk("R1 low", 256'(low_entropy), 0);
    chk("R1 cells", 256'({cell_bias, cell_score}), 0);
    chk("R1 ctl0", 256'(ctl_words[0]), 256'({3'b001, 2'd0, 1'b1, 16'd0}));
    chk("R1 ctl2", 256'(ctl_words[2]), 256'({3'b100, 2'd2, 1'b1, 16'd0}));
  endtask

  task automatic t_zero_default();
    full_run("R5 all-zero", 16'd77);
    chk("R5 default kept", 256'(bias_word), 256'(6'h24));
  endtask

  task automatic t_pseudo_random();
    logic [63:0] v [3][4];
    for (int r = 0; r < 3; r++) begin
      for (int o = 0; o < 3; o++)
        for (int b = 0; b < 4; b++) begin
          lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
          v[o][b] = (lcg >> 20) % 64'd120000000;
        end
      load_all(v);
      full_run("R4 random", 16'(1000 + r));
    end
  endtask

  task automatic t_same_bias_trap();
    logic [63:0] v [3][4];
    for (int o = 0; o < 3; o++)
      for (int b = 0; b < 4; b++) v[o][b] = (b == 1) ? 64'd900000000 : 64'(10 + o * 4 + b);
    load_all(v);
    full_run("R3 same-bias trap", 16'h0F0F);
  endtask

  task automatic t_tie();
    logic [63:0] v [3][4];
    for (int o = 0; o < 3; o++)
      for (int b = 0; b < 4; b++) v[o][b] = 0;
    v[0][3] = 64'd100000000; v[1][2] = 64'd100000000;
    load_all(v);
    full_run("R4 tie", 16'd5);
    chk("R4 first maximum wins", 256'(bias_word), 256'(6'b00_10_11));
  endtask

  task automatic t_low();
    logic [63:0] v [3][4];
    for (int o = 0; o < 3; o++)
      for (int b = 0; b < 4; b++) v[o][b] = 64'(1000 * (o + 1) + b);
    load_all(v);
    full_run("R7 low", 16'd9);
    chk("R7 flag raised", 256'(low_entropy), 1);
    // exactly at threshold passes
    for (int o = 0; o < 3; o++)
      for (int b = 0; b < 4; b++) v[o][b] = 0;
    v[0][0] = 64'd50000000; v[1][1] = 64'd50000000; v[2][2] = 64'd50000000;
    load_all(v);
    full_run("R7 threshold", 16'd10);
    chk("R7 equal threshold passes", 256'(low_entropy), 0);
  endtask

  task automatic t_overflow();
    logic [63:0] v [3][4];
    for (int o = 0; o < 3; o++)
      for (int b = 0; b < 4; b++) v[o][b] = '1;
    load_all(v);
    full_run("R12 max", 16'hFFFF);
    chk("R12 no overflow", 256'(best_sum), 256'(66'h2FFFFFFFFFFFFFFFD));
  endtask

  task automatic t_ignored_writes();
    logic [63:0] v [3][4];
    int n;
    for (int o = 0; o < 3; o++)
      for (int b = 0; b < 4; b++) v[o][b] = 64'(60000000 + o * 1000 + b * 7);
    load_all(v);
    wr(2'd3, 2'd1, '1);
    full_run("R2 osc3 write ignored", 16'd33);
    run(16'd44, 0, 1, n);
    chk("R2 mid-run write: cycles", 256'(n), 256'(25));
    check_result("R2 mid-run write", 16'd44);
    full_run("R2 table unchanged after busy write", 16'd45);
  endtask

  task automatic t_restart_ignored();
    int n;
    run(16'h1357, 1, 0, n);
    chk("R11 start while busy: cycles", 256'(n), 256'(25));
    check_result("R11 count kept", 16'h1357);
  endtask

  initial begin
    for (int o = 0; o < 3; o++)
      for (int b = 0; b < 4; b++) mt[o][b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero_default();
    t_pseudo_random();
    t_same_bias_trap();
    t_tie();
    t_low();
    t_overflow();
    t_ignored_writes();
    t_restart_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule